// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel sitting beside a free-running up/down counter. While the channel is armed for capture, a one-cycle event strobe copies the present counter value into the channel's holding register and raises the channel's match flag. Software or a downstream consumer reads the held value and then writes 1 to the match-flag clear strobe. A new event that arrives before the flag is cleared is refused: the held value is kept and a sticky error flag is raised.

Besides plain capture, the channel can track the smallest or the largest value seen so far. When the counter runs in dual-slope fashion with a TOP value well below the counter's full range, the top bit of each stored value is replaced by the direction of the ramp, so that a reader can tell which slope the capture came from. The counter, the routing of events and any interrupt logic lie outside this block.

Top module: `cap_chan`

## Requirements
- R1: When the capture-enable input is 0, a capture event changes neither the held value, the match flag nor the error flag.
- R2: In plain mode (mode code 0, and the unused code 3), an enabled event while the match flag is 0 stores the count and sets the match flag; both are visible one clock after the event.
- R3: An enabled event while the match flag is 1 is refused: the held value is unchanged and the error flag is 1 one clock later.
- R4: The error flag stays set until a cycle with the error-clear strobe at 1; a refused event in that same cycle keeps it set.
- R5: The match-flag clear strobe drops the flag one clock later; a store in the same cycle wins and the flag stays 1. Nothing else clears the flag.
- R6: In minimum mode (mode code 1), the first enabled event after reset always stores; later events store only a value strictly below the held one. The match flag is set only when a store happens.
- R7: In maximum mode (mode code 2), the first enabled event after reset always stores; later events store only a value strictly above the held one, and the match flag is set only on a store.
- R8: In minimum mode while counting up (direction input 0), a count of 0 is never stored; while counting down a count of 0 can be stored.
- R9: When dual-slope is 1 and TOP is below half the counter maximum (TOP < 2^(W-1)-1), the stored value's MSB is the direction input (1 = falling ramp, 0 = rising) and the lower bits are the count; otherwise the full count is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Present counter value |
| dir_down_i | input | 1 | Counting direction, 1 = down |
| top_i | input | CNT_W | Counter TOP value |
| dual_slope_i | input | 1 | Counter runs in dual-slope fashion |
| cap_en_i | input | 1 | Channel is armed for capture |
| mode_i | input | 2 | 0 plain, 1 minimum, 2 maximum, 3 plain |
| cap_evt_i | input | 1 | Capture event strobe |
| mf_clr_i | input | 1 | Write-1 clear of the match flag |
| err_clr_i | input | 1 | Write-1 clear of the error flag |
| cap_val_o | output | CNT_W | Held capture value |
| mf_o | output | 1 | Match flag |
| err_o | output | 1 | Capture overflow error flag |

## Verification
The assertions assume every input is a known value that settles between clock edges and that the event strobe is meaningful only in the cycle it is high; the bench changes inputs only at falling edges. The minimum/maximum properties take the flag's first rise after reset as the point from which comparisons apply, so the stimulus begins each tracking mode only after a store has happened or checks the first store on its own. Mode code 3 is left to the random phase, where it must behave as plain capture.

// File: rtl/cap_chan_pkg.sv
package cap_chan_pkg;
    typedef enum logic [1:0] {
        CM_PLAIN = 2'd0,
        CM_MIN   = 2'd1,
        CM_MAX   = 2'd2,
        CM_RSVD  = 2'd3
    } cap_mode_e;
endpackage

// File: rtl/cap_chan_tag.sv
// Builds the value to store: the raw count, or the count with its top bit
// replaced by the ramp direction when a short dual-slope period is in use.
module cap_chan_tag #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             dir_down_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             dual_slope_i,
    output logic [CNT_W-1:0] cand_o
);
    localparam logic [CNT_W-1:0] HALF_MAX = {1'b0, {(CNT_W-1){1'b1}}};

    logic tag_on;

    always_comb begin
        tag_on = dual_slope_i && (top_i < HALF_MAX);
        if (tag_on) begin
            cand_o = {dir_down_i, cnt_i[CNT_W-2:0]};
        end else begin
            cand_o = cnt_i;
        end
    end
endmodule

// File: rtl/cap_chan_sel.sv
// Decides whether an accepted event may overwrite the held value.
module cap_chan_sel
    import cap_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] cand_i,
    input  logic [CNT_W-1:0] held_i,
    input  logic             seeded_i,
    input  logic             dir_down_i,
    input  logic [CNT_W-1:0] raw_cnt_i,
    output logic             take_o
);
    logic zero_up;

    always_comb begin
        zero_up = !dir_down_i && (raw_cnt_i == '0);
        unique case (cap_mode_e'(mode_i))
            CM_MIN:  take_o = !zero_up && (!seeded_i || (cand_i < held_i));
            CM_MAX:  take_o = !seeded_i || (cand_i > held_i);
            default: take_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/cap_chan.sv
module cap_chan
    import cap_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             dir_down_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             dual_slope_i,
    input  logic             cap_en_i,
    input  logic [1:0]       mode_i,
    input  logic             cap_evt_i,
    input  logic             mf_clr_i,
    input  logic             err_clr_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             mf_o,
    output logic             err_o
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             seeded;
        logic             mf;
        logic             err;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic [CNT_W-1:0] cand;
    logic             take;
    logic             accept;
    logic             refuse;
    logic             store;

    cap_chan_tag #(.CNT_W(CNT_W)) u_tag (
        .cnt_i        (cnt_i),
        .dir_down_i   (dir_down_i),
        .top_i        (top_i),
        .dual_slope_i (dual_slope_i),
        .cand_o       (cand)
    );

    cap_chan_sel #(.CNT_W(CNT_W)) u_sel (
        .mode_i     (mode_i),
        .cand_i     (cand),
        .held_i     (st_q.val),
        .seeded_i   (st_q.seeded),
        .dir_down_i (dir_down_i),
        .raw_cnt_i  (cnt_i),
        .take_o     (take)
    );

    always_comb begin
        accept = cap_evt_i && cap_en_i;
        refuse = accept && st_q.mf;
        store  = accept && !st_q.mf && take;

        st_d        = st_q;
        st_d.val    = store ? cand : st_q.val;
        st_d.seeded = st_q.seeded || store;
        st_d.mf     = store || (st_q.mf && !mf_clr_i);
        st_d.err    = refuse || (st_q.err && !err_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_val_o = st_q.val;
    assign mf_o      = st_q.mf;
    assign err_o     = st_q.err;
endmodule

// File: rtl/cap_chan_chk.sv
module cap_chan_chk
    import cap_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_i,
    input logic             dir_down_i,
    input logic             dual_slope_i,
    input logic             cap_en_i,
    input logic [1:0]       mode_i,
    input logic             cap_evt_i,
    input logic             mf_clr_i,
    input logic             err_clr_i,
    input logic [CNT_W-1:0] cap_val_o,
    input logic             mf_o,
    input logic             err_o
);
    logic seen_q;
    logic fire;

    assign fire = cap_en_i && cap_evt_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (mf_o) seen_q <= 1'b1;
    end

    a_r1_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en_i && cap_evt_i) |=> ($stable(cap_val_o) && !$rose(err_o) && !$rose(mf_o)));

    a_r2_plain_store: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !mf_o && !dual_slope_i && (mode_i == CM_PLAIN))
        |=> (mf_o && (cap_val_o == $past(cnt_i))));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mf_o) |=> (err_o && $stable(cap_val_o)));

    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr_i) |=> err_o);

    a_r5_mf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_clr_i && !fire) |=> !mf_o);

    a_r6_min_down: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !mf_o && seen_q && (mode_i == CM_MIN)) |=> (cap_val_o <= $past(cap_val_o)));

    a_r7_max_up: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !mf_o && seen_q && (mode_i == CM_MAX)) |=> (cap_val_o >= $past(cap_val_o)));

    a_r8_min_zero_up: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !mf_o && (mode_i == CM_MIN) && !dir_down_i && (cnt_i == '0))
        |=> (!mf_o && $stable(cap_val_o)));
endmodule

bind cap_chan cap_chan_chk #(.CNT_W(CNT_W)) u_cap_chan_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_i        (cnt_i),
    .dir_down_i   (dir_down_i),
    .dual_slope_i (dual_slope_i),
    .cap_en_i     (cap_en_i),
    .mode_i       (mode_i),
    .cap_evt_i    (cap_evt_i),
    .mf_clr_i     (mf_clr_i),
    .err_clr_i    (err_clr_i),
    .cap_val_o    (cap_val_o),
    .mf_o         (mf_o),
    .err_o        (err_o)
);

// File: tb/cap_chan_bench.sv
module cap_chan_bench;
    localparam int CNT_W  = 16;
    localparam time CLK_P = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_i = '0;
    logic             dir_down_i = 1'b0;
    logic [CNT_W-1:0] top_i = '1;
    logic             dual_slope_i = 1'b0;
    logic             cap_en_i = 1'b0;
    logic [1:0]       mode_i = 2'd0;
    logic             cap_evt_i = 1'b0;
    logic             mf_clr_i = 1'b0;
    logic             err_clr_i = 1'b0;
    logic [CNT_W-1:0] cap_val_o;
    logic             mf_o;
    logic             err_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    longint m_val = 0;
    bit     m_mf = 0, m_err = 0, m_seed = 0;

    always #(CLK_P/2) clk = ~clk;

    cap_chan #(.CNT_W(CNT_W)) u_cap_chan (.*);

    function automatic longint ref_cand();
        longint half_max = (longint'(1) << (CNT_W-1)) - 1;
        if (dual_slope_i && (longint'(top_i) < half_max))
            return (longint'(dir_down_i) << (CNT_W-1)) | (longint'(cnt_i) & half_max);
        return longint'(cnt_i);
    endfunction

    // one reference step using the inputs held over the coming edge
    task automatic ref_step();
        bit acc, ok, st, rej;
        longint c;
        acc = cap_evt_i && cap_en_i;
        c   = ref_cand();
        case (mode_i)
            2'd1:    ok = !(dir_down_i == 0 && cnt_i == 0) && (!m_seed || c < m_val);
            2'd2:    ok = !m_seed || c > m_val;
            default: ok = 1;
        endcase
        rej = acc && m_mf;
        st  = acc && !m_mf && ok;
        if (st) begin m_val = c; m_seed = 1; end
        m_mf  = st || (m_mf && !mf_clr_i);
        m_err = rej || (m_err && !err_clr_i);
    endtask

    task automatic check(string tag);
        total++;
        if (longint'(cap_val_o) != m_val || mf_o != m_mf || err_o != m_err) begin
            bad++;
            $display("FAIL %s: val=%h mf=%0d err=%0d expected val=%h mf=%0d err=%0d",
                     tag, cap_val_o, mf_o, err_o, m_val[CNT_W-1:0], m_mf, m_err);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        ref_step();
        @(negedge clk);
        check(tag);
        cap_evt_i = 0; mf_clr_i = 0; err_clr_i = 0;
    endtask

    task automatic ev(string tag, logic [CNT_W-1:0] c);
        cnt_i = c; cap_evt_i = 1;
        tick(tag);
    endtask

    task automatic clr_mf(string tag);
        mf_clr_i = 1;
        tick(tag);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("reset");
        rst_n = 1;
        @(negedge clk);

        // R1: disarmed channel ignores events
        cap_en_i = 0;
        ev("R1", 16'h1234);
        ev("R1", 16'h0000);

        // R2: plain capture
        cap_en_i = 1; mode_i = 2'd0;
        ev("R2", 16'h0100);
        clr_mf("R2");
        ev("R2", 16'hBEEF);

        // R3: overflow refused while flag set
        ev("R3", 16'h0200);
        tick("R3");

        // R4: error clear, and refused event beats the clear
        err_clr_i = 1; tick("R4");
        tick("R4");
        err_clr_i = 1; ev("R4", 16'h0333);
        err_clr_i = 1; tick("R4");

        // R5: flag clear; store wins over simultaneous clear
        clr_mf("R5");
        tick("R5");
        mf_clr_i = 1; ev("R5", 16'h0444);
        clr_mf("R5");

        // R6: minimum tracking
        mode_i = 2'd1;
        ev("R6", 16'h0300); clr_mf("R6");
        ev("R6", 16'h0500); tick("R6");
        ev("R6", 16'h0300); clr_mf("R6");
        ev("R6", 16'h0010); clr_mf("R6");

        // R8: zero on up-count is lost, on down-count it is kept
        dir_down_i = 0; ev("R8", 16'h0000); tick("R8");
        dir_down_i = 1; ev("R8", 16'h0000); clr_mf("R8");
        dir_down_i = 0;

        // R7: maximum tracking
        mode_i = 2'd2;
        ev("R7", 16'h0005); clr_mf("R7");
        ev("R7", 16'h9000); clr_mf("R7");
        ev("R7", 16'h8FFF); tick("R7");
        ev("R7", 16'h9000); tick("R7");

        // R9: direction tagging in dual-slope with short TOP
        mode_i = 2'd0; dual_slope_i = 1; top_i = 16'h1000;
        dir_down_i = 1; ev("R9", 16'h0800); clr_mf("R9");
        dir_down_i = 0; ev("R9", 16'h0801); clr_mf("R9");
        top_i = 16'h7FFF; dir_down_i = 1; ev("R9", 16'h0802); clr_mf("R9");
        top_i = 16'h7FFE; ev("R9", 16'h8803); clr_mf("R9");
        dual_slope_i = 0; top_i = 16'hFFFF; dir_down_i = 0;

        // mixed random traffic across all modes
        for (int i = 0; i < 400; i++) begin
            cnt_i        = CNT_W'($urandom);
            if ($urandom_range(0, 3) == 0) cnt_i = '0;
            dir_down_i   = 1'($urandom);
            dual_slope_i = 1'($urandom);
            top_i        = CNT_W'($urandom);
            cap_en_i     = ($urandom_range(0, 4) != 0);
            mode_i       = 2'($urandom);
            cap_evt_i    = 1'($urandom);
            mf_clr_i     = ($urandom_range(0, 2) == 0);
            err_clr_i    = ($urandom_range(0, 3) == 0);
            tick("RND");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule